// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block produces the active-low read and write strobes of a parallel ATA channel for programmed-I/O data cycles, multiword DMA data cycles and task-file register cycles. A controller gives one start pulse per cycle, together with a read/write select, a flag that marks task-file access rather than data access, a flag that marks the cycle as the continuation of a data burst, and a 32-bit per-device timing word. Every phase length comes from a field of that word and is counted in bus-clock cycles as the field value plus one.

A cycle has up to three phases. A setup phase comes first, with both strobes high, and it is skipped for a continued data burst. The selected strobe is then held low for the active width. Both strobes then stay high for the inactive width. Data cycles and task-file cycles take their setup, active and inactive widths from separate fields. One clock after the inactive phase the block raises a one-cycle done pulse. At that point it is already idle and can accept the next start. The four enable bits at the top of the word are not acted on. The block only reports them, as captured at the last accepted start.

Top module: `ata_strobe_gen`

## Requirements
- R1: While reset is held, and until the first start after reset, both strobes are high, busy and done are low, and all four enable outputs are low.
- R2: A data cycle (taskfile_i low) runs a setup phase of bits 24:22 + 1 clocks, then an active phase of bits 8:4 + 1 clocks, then an inactive phase of bits 3:0 + 1 clocks.
- R3: A task-file cycle (taskfile_i high) runs a setup phase of bits 27:25 + 1 clocks, then an active phase of bits 17:13 + 1 clocks, then an inactive phase of bits 12:9 + 1 clocks.
- R4: In the active phase only the read strobe is low when write_i was 0, and only the write strobe is low when write_i was 1. The two strobes are never low together, and both are high whenever the block is not busy.
- R5: A data cycle started with burst_i high has no setup phase: the strobe goes low in the first busy clock. A task-file cycle keeps its setup phase whatever the value of burst_i.
- R6: busy_o is high from the clock after the accepted start to the last clock of the inactive phase. done_o is high for exactly one clock, the first clock after busy falls.
- R7: timing_i, write_i, taskfile_i and burst_i are sampled at the accepted start. Changing them during a cycle alters neither the phase widths nor the strobe in use.
- R8: A start pulse that arrives while busy is ignored and is not queued: the running cycle completes unchanged and the block stays idle after it.
- R9: The enable outputs report bits 28 (ultra DMA), 29 (DMA), 30 (bus-master PIO) and 31 (FIFO) of the word captured at the last accepted start, and hold those values until the next accepted start.
- R10: A start given in the clock where done_o is high is accepted, so cycles can run back to back with no idle clock between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one strobe cycle (accepted when idle) |
| write_i | input | 1 | 1 = write strobe, 0 = read strobe |
| taskfile_i | input | 1 | 1 = task-file register cycle, 0 = data cycle |
| burst_i | input | 1 | Continued data burst: skip the setup phase |
| timing_i | input | 32 | Per-device timing word |
| dior_n_o | output | 1 | Active-low read strobe |
| diow_n_o | output | 1 | Active-low write strobe |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| udma_en_o | output | 1 | Captured ultra DMA enable (bit 28) |
| dma_en_o | output | 1 | Captured DMA enable (bit 29) |
| pio_master_en_o | output | 1 | Captured bus-master PIO enable (bit 30) |
| fifo_en_o | output | 1 | Captured FIFO enable (bit 31) |

## Verification
The assertions check on every cycle that the two strobes are never low together, that both stay high while idle, that done is a single-clock pulse that comes with the fall of busy, that a start arriving while busy leaves the captured word untouched, and that the phase counter never exceeds the width of its phase. Only the bench scenarios can show that each phase lasts exactly its field value plus one, that data and task-file cycles take their widths from the correct fields, that a burst continuation removes the setup phase, that the reported enables follow the captured word, and that a start given in the done clock is accepted.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

  localparam int WORD_W  = 32;
  localparam int CNT_W   = 5;
  localparam int ENA_LSB = 28;
  localparam int ENA_N   = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  // Packed layout of the timing word, most significant field first.
  typedef struct packed {
    logic       fifo_en;      // 31
    logic       pio_mst_en;   // 30
    logic       dma_en;       // 29
    logic       udma_en;      // 28
    logic [2:0] cmd_setup;    // 27:25
    logic [2:0] data_setup;   // 24:22
    logic [3:0] udma_cyc;     // 21:18 (not used by this block)
    logic [4:0] cmd_act;      // 17:13
    logic [3:0] cmd_rec;      // 12:9
    logic [4:0] data_act;     // 8:4
    logic [3:0] data_rec;     // 3:0
  } tword_t;

  typedef struct packed {
    logic [CNT_W-1:0] setup_len;
    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] rec_len;
    logic             skip_setup;
  } cyc_cfg_t;

endpackage

// File: rtl/ata_tword_capture.sv
module ata_tword_capture
  import ata_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              write_i,
  input  logic              tf_i,
  input  logic              burst_i,
  output cyc_cfg_t          cfg_o,
  output logic              write_o,
  output logic [ENA_N-1:0]  enables_o
);

  logic [WORD_W-1:0] word_q, word_d;
  logic              write_q, write_d;
  logic              tf_q, tf_d;
  logic              burst_q, burst_d;
  tword_t            tw;

  // Clock enable: the next value is the input only on an accepted start.
  always_comb begin
    if (load_i) begin
      word_d  = word_i;
      write_d = write_i;
      tf_d    = tf_i;
      burst_d = burst_i;
    end else begin
      word_d  = word_q;
      write_d = write_q;
      tf_d    = tf_q;
      burst_d = burst_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      write_q <= 1'b0;
      tf_q    <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      write_q <= write_d;
      tf_q    <= tf_d;
      burst_q <= burst_d;
    end
  end

  // Decode from the next value so the sequencer can load its counter
  // in the same edge that accepts the start.
  assign tw = tword_t'(word_d);

  always_comb begin
    if (tf_d) begin
      cfg_o.setup_len = CNT_W'(tw.cmd_setup);
      cfg_o.act_len   = CNT_W'(tw.cmd_act);
      cfg_o.rec_len   = CNT_W'(tw.cmd_rec);
    end else begin
      cfg_o.setup_len = CNT_W'(tw.data_setup);
      cfg_o.act_len   = CNT_W'(tw.data_act);
      cfg_o.rec_len   = CNT_W'(tw.data_rec);
    end
    cfg_o.skip_setup = burst_d & ~tf_d;
  end

  assign write_o = write_q;

  generate
    for (genvar i = 0; i < ENA_N; i++) begin : g_ena
      assign enables_o[i] = word_q[ENA_LSB+i];
    end
  endgenerate

  // R8 / R7: a start seen while busy must leave the captured word alone
  assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !load_i) |=> $stable(word_q) && $stable(write_q) && $stable(tf_q));

endmodule

// File: rtl/ata_phase_seq.sv
module ata_phase_seq
  import ata_strobe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  cyc_cfg_t cfg_i,
  output logic     accept_o,
  output phase_e   phase_o,
  output logic     busy_o,
  output logic     done_o
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             last;

  assign accept_o = start_i && (phase_q == PH_IDLE);
  assign last     = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept_o) begin
          if (cfg_i.skip_setup) begin
            phase_d = PH_ACTIVE;
            cnt_d   = cfg_i.act_len;
          end else begin
            phase_d = PH_SETUP;
            cnt_d   = cfg_i.setup_len;
          end
        end
      end
      PH_SETUP: begin
        if (last) begin
          phase_d = PH_ACTIVE;
          cnt_d   = cfg_i.act_len;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (last) begin
          phase_d = PH_RECOV;
          cnt_d   = cfg_i.rec_len;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_RECOV: begin
        if (last) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;

  // R6: done is a single-clock pulse
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: busy only falls together with a done pulse
  assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_q);

  // R2 / R3: active counter stays within the captured active width
  assert_act_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACTIVE) |-> (cnt_q <= cfg_i.act_len));

endmodule

// File: rtl/ata_strobe_drv.sv
module ata_strobe_drv
  import ata_strobe_pkg::*;
(
  input  phase_e phase_i,
  input  logic   write_i,
  output logic   dior_n_o,
  output logic   diow_n_o
);

  logic strobe_on;

  assign strobe_on = (phase_i == PH_ACTIVE);

  always_comb begin
    dior_n_o = 1'b1;
    diow_n_o = 1'b1;
    if (strobe_on) begin
      if (write_i) diow_n_o = 1'b0;
      else         dior_n_o = 1'b0;
    end
  end

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
  import ata_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              write_i,
  input  logic              taskfile_i,
  input  logic              burst_i,
  input  logic [WORD_W-1:0] timing_i,
  output logic              dior_n_o,
  output logic              diow_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              udma_en_o,
  output logic              dma_en_o,
  output logic              pio_master_en_o,
  output logic              fifo_en_o
);

  logic             rst_meta_q, rst_sync_q;
  logic             accept;
  logic             write_cap;
  cyc_cfg_t         cfg;
  phase_e           phase;
  logic [ENA_N-1:0] enables;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ata_tword_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load_i    (accept),
    .busy_i    (busy_o),
    .word_i    (timing_i),
    .write_i   (write_i),
    .tf_i      (taskfile_i),
    .burst_i   (burst_i),
    .cfg_o     (cfg),
    .write_o   (write_cap),
    .enables_o (enables)
  );

  ata_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .start_i  (start_i),
    .cfg_i    (cfg),
    .accept_o (accept),
    .phase_o  (phase),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  ata_strobe_drv u_drv (
    .phase_i  (phase),
    .write_i  (write_cap),
    .dior_n_o (dior_n_o),
    .diow_n_o (diow_n_o)
  );

  assign udma_en_o       = enables[0];
  assign dma_en_o        = enables[1];
  assign pio_master_en_o = enables[2];
  assign fifo_en_o       = enables[3];

  // R4: never both strobes low
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    dior_n_o || diow_n_o);

  // R4 / R1: both strobes high while idle
  assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy_o |-> (dior_n_o && diow_n_o));

  // R1: asynchronous reset holds the strobes inactive
  always_comb begin
    if (!rst_n) begin
      assert_reset_high_R1: assert (dior_n_o && diow_n_o);
    end
  end

endmodule

// File: tb/ata_strobe_gen_test.sv
module ata_strobe_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, write_i, taskfile_i, burst_i;
  logic [31:0] timing_i;
  logic        dior_n_o, diow_n_o, busy_o, done_o;
  logic        udma_en_o, dma_en_o, pio_master_en_o, fifo_en_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ata_strobe_gen uut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .write_i (write_i),
    .taskfile_i (taskfile_i), .burst_i (burst_i), .timing_i (timing_i),
    .dior_n_o (dior_n_o), .diow_n_o (diow_n_o), .busy_o (busy_o), .done_o (done_o),
    .udma_en_o (udma_en_o), .dma_en_o (dma_en_o),
    .pio_master_en_o (pio_master_en_o), .fifo_en_o (fifo_en_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Word layout per R2, R3, R9.
  function automatic logic [31:0] mkw(input logic [3:0] ena, input logic [2:0] cs,
      input logic [2:0] ds, input logic [4:0] ca, input logic [3:0] cr,
      input logic [4:0] da, input logic [3:0] dr);
    return {ena, cs, ds, 4'hA, ca, cr, da, dr};
  endfunction

  // Runs one cycle and returns at the negedge where done is seen.
  task automatic run_cycle(input logic [31:0] w, input logic wr, input logic tf,
      input logic bc, input int es, input int ea, input int er,
      input bit disturb, input string req);
    int s = 0, a = 0, r = 0, bad = 0;
    bit seen_low = 0, got_done = 0;
    timing_i = w; write_i = wr; taskfile_i = tf; burst_i = bc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 300 && !got_done; k++) begin
      if (done_o) got_done = 1;
      else begin
        if (disturb && k == 0) begin
          timing_i = '0; write_i = ~wr; taskfile_i = ~tf; burst_i = ~bc; start_i = 1'b1;
        end else if (disturb && k == 1) start_i = 1'b0;
        if (!dior_n_o || !diow_n_o) begin
          a++; seen_low = 1;
          if ((wr && !dior_n_o) || (!wr && !diow_n_o) || (!dior_n_o && !diow_n_o)) bad++;
        end else if (busy_o && !seen_low) s++;
        else if (busy_o) r++;
        @(negedge clk);
      end
    end
    check(got_done, req, "done seen", got_done, 1);
    check(s == es, req, "setup clocks", s, es);
    check(a == ea, req, "active clocks", a, ea);
    check(r == er, req, "inactive clocks", r, er);
    check(bad == 0, "R4", "wrong strobe clocks", bad, 0);
    check(!busy_o, "R6", "busy in done clock", busy_o, 0);
    check({fifo_en_o, pio_master_en_o, dma_en_o, udma_en_o} == w[31:28], "R9",
          "enables", {fifo_en_o, pio_master_en_o, dma_en_o, udma_en_o}, w[31:28]);
  endtask

  task automatic check_quiet(input string req);
    @(negedge clk);
    check(!done_o, "R6", "done width", done_o, 0);
    check(!busy_o, req, "idle after cycle", busy_o, 0);
    check(dior_n_o && diow_n_o, "R4", "strobes high idle", {dior_n_o, diow_n_o}, 3);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_i = 0; write_i = 0; taskfile_i = 0; burst_i = 0; timing_i = '1;
    repeat (3) @(negedge clk);
    check(dior_n_o && diow_n_o, "R1", "strobes in reset", {dior_n_o, diow_n_o}, 3);
    check(!busy_o && !done_o, "R1", "busy/done in reset", {busy_o, done_o}, 0);
    check({fifo_en_o, pio_master_en_o, dma_en_o, udma_en_o} == 0, "R1", "enables in reset",
          {fifo_en_o, pio_master_en_o, dma_en_o, udma_en_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && dior_n_o && diow_n_o, "R1", "idle after release",
          {busy_o, dior_n_o, diow_n_o}, 3);
  endtask

  task automatic t_data;
    logic [31:0] w = mkw(4'b1010, 3'd4, 3'd2, 5'd9, 4'd7, 5'd5, 4'd3);
    run_cycle(w, 1'b0, 1'b0, 1'b0, 3, 6, 4, 0, "R2"); check_quiet("R2");
    run_cycle(w, 1'b1, 1'b0, 1'b0, 3, 6, 4, 0, "R2"); check_quiet("R4");
  endtask

  task automatic t_taskfile;
    logic [31:0] w = mkw(4'b0101, 3'd4, 3'd2, 5'd9, 4'd7, 5'd5, 4'd3);
    run_cycle(w, 1'b0, 1'b1, 1'b0, 5, 10, 8, 0, "R3"); check_quiet("R3");
    run_cycle(w, 1'b1, 1'b1, 1'b0, 5, 10, 8, 0, "R3"); check_quiet("R3");
  endtask

  task automatic t_burst;
    logic [31:0] w = mkw(4'b0011, 3'd6, 3'd5, 5'd2, 4'd1, 5'd3, 4'd2);
    run_cycle(w, 1'b1, 1'b0, 1'b1, 0, 4, 3, 0, "R5"); check_quiet("R5");
    run_cycle(w, 1'b0, 1'b1, 1'b1, 7, 3, 2, 0, "R5"); check_quiet("R5");
  endtask

  task automatic t_disturb;
    logic [31:0] w = mkw(4'b1100, 3'd1, 3'd3, 5'd6, 4'd2, 5'd4, 4'd5);
    // R7 and R8: inputs change and a second start arrives while busy
    run_cycle(w, 1'b0, 1'b0, 1'b0, 4, 5, 6, 1, "R7");
    check_quiet("R8");
    check_quiet("R8");
  endtask

  task automatic t_back_to_back;
    logic [31:0] w1 = mkw(4'b0001, 3'd0, 3'd1, 5'd0, 4'd0, 5'd2, 4'd1);
    logic [31:0] w2 = mkw(4'b1000, 3'd2, 3'd0, 5'd3, 4'd1, 5'd1, 4'd0);
    run_cycle(w1, 1'b1, 1'b0, 1'b0, 2, 3, 2, 0, "R10");
    run_cycle(w2, 1'b0, 1'b1, 1'b0, 3, 4, 2, 0, "R10");
    check_quiet("R10");
  endtask

  task automatic t_extremes;
    run_cycle(mkw(4'b0000, 3'd0, 3'd0, 5'd0, 4'd0, 5'd0, 4'd0), 1'b0, 1'b0, 1'b0,
              1, 1, 1, 0, "R2");
    check_quiet("R2");
    run_cycle(mkw(4'b1111, 3'd7, 3'd7, 5'd31, 4'd15, 5'd31, 4'd15), 1'b1, 1'b0, 1'b0,
              8, 32, 16, 0, "R2");
    check_quiet("R2");
    run_cycle(mkw(4'b1111, 3'd7, 3'd7, 5'd31, 4'd15, 5'd31, 4'd15), 1'b0, 1'b1, 1'b0,
              8, 32, 16, 0, "R3");
    check_quiet("R3");
  endtask

  initial begin
    t_reset;
    t_data;
    t_taskfile;
    t_burst;
    t_disturb;
    t_back_to_back;
    t_extremes;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule